// File: doc/BRIEF.md
# Infrared Transmit Pin Conditioner

This block prepares a single output pin that drives an infrared LED for an optical serial port, and it gates the matching receive pin on its way to a UART receiver. A 2-bit source select picks the signal that drives the LED: the UART transmit line, a real-energy pulse, a reactive-energy pulse, or a general-purpose output bit. The chosen bit either passes straight through or, with modulation turned on, keys a 38 kHz carrier whose high time is set by a 2-bit duty code. A final polarity control can invert the pin.

The carrier comes from a free-running divider on the system clock. Its period, counted in clock cycles, is a parameter. The default of 128 cycles suits a clock of about 4.86 MHz. When modulation is on, a data bit of 0 (the UART space state) sends carrier bursts and a data bit of 1 leaves the LED dark. On the receive side, a disable bit forces the UART input to the idle level.

Top module: `optical_tx_conditioner`

## Requirements
- R1: `src_sel` chooses the transmit data bit. Code 0 selects `uart_tx`, 1 selects `wpulse`, 2 selects `varpulse` and 3 selects `gpo_bit`.
- R2: While `mod_en` is 0, `pad_tx` equals the selected data bit XOR `tx_invert`, one clock cycle after the inputs are applied.
- R3: `tx_invert` = 1 inverts `pad_tx` in both the unmodulated and the modulated mode.
- R4: While `mod_en` is 1 and the selected data bit is 1, `pad_tx` holds the idle level, which is 0 (1 when inverted).
- R5: While `mod_en` is 1 and the selected data bit is 0, `pad_tx` is a square carrier whose period is exactly `PERIOD_CLKS` clock cycles.
- R6: `duty_code` values 0, 1, 2 and 3 give a carrier high time of 4/8, 3/8, 2/8 and 1/8 of `PERIOD_CLKS`. With inversion on, the high time becomes the remainder of the period.
- R7: While `rx_disable` is 1, `uart_rx` is 1. While it is 0, `uart_rx` follows `pad_rx`.
- R8: During reset `pad_tx` is 0, and the carrier phase restarts at the beginning of its high time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 2 | Transmit source select |
| mod_en | input | 1 | Carrier modulation enable |
| duty_code | input | 2 | Carrier high-time code |
| tx_invert | input | 1 | Output polarity invert |
| rx_disable | input | 1 | Block receive pin from UART |
| uart_tx | input | 1 | UART transmit line |
| wpulse | input | 1 | Real-energy pulse |
| varpulse | input | 1 | Reactive-energy pulse |
| gpo_bit | input | 1 | General-purpose output value |
| pad_rx | input | 1 | Receive pin from photodiode |
| pad_tx | output | 1 | LED drive pin |
| uart_rx | output | 1 | Gated receive to UART |

## Verification
The hardest behaviour to see from the ports is the carrier duty: the divider phase is hidden, so the phase of any single sample is unknown. The stimulus holds the modulated space state for more than one full period and counts high samples over exactly `PERIOD_CLKS` consecutive cycles. That count does not depend on the phase. The period is measured between two rising edges of the pin.

// File: rtl/optx_pkg.sv
package optx_pkg;

  typedef enum logic [1:0] {
    SRC_UART = 2'd0,
    SRC_WPLS = 2'd1,
    SRC_VPLS = 2'd2,
    SRC_GPO  = 2'd3
  } optx_src_e;

  // Carrier high time in clocks: period * (4 - code) / 8
  function automatic int unsigned optx_high_clks(input int unsigned period,
                                                 input logic [1:0] code);
    int unsigned eighths;
    eighths = 4 - int'(code);
    return (period * eighths) / 8;
  endfunction

endpackage

// File: rtl/optx_src_mux.sv
module optx_src_mux
  import optx_pkg::*;
(
  input  logic [1:0] sel,
  input  logic       uart_tx,
  input  logic       wpulse,
  input  logic       varpulse,
  input  logic       gpo_bit,
  output logic       data
);
  always_comb begin
    unique case (optx_src_e'(sel))
      SRC_UART: data = uart_tx;
      SRC_WPLS: data = wpulse;
      SRC_VPLS: data = varpulse;
      SRC_GPO:  data = gpo_bit;
      default:  data = 1'b1;
    endcase
  end
endmodule

// File: rtl/optx_carrier_gen.sv
module optx_carrier_gen
  import optx_pkg::*;
#(
  parameter int unsigned PERIOD_CLKS = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] duty_code,
  output logic       carrier,
  output logic       wrap
);
  localparam int unsigned CW = (PERIOD_CLKS > 2) ? $clog2(PERIOD_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD_CLKS - 1);

  logic [CW-1:0] cnt_q;
  logic [CW:0]   high_clks;

  assign high_clks = (CW+1)'(optx_high_clks(PERIOD_CLKS, duty_code));
  assign wrap      = (cnt_q == LAST);
  assign carrier   = ({1'b0, cnt_q} < high_clks);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (wrap) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/optx_rx_gate.sv
module optx_rx_gate (
  input  logic rx_disable,
  input  logic pad_rx,
  output logic uart_rx
);
  assign uart_rx = rx_disable | pad_rx;
endmodule

// File: rtl/optical_tx_conditioner.sv
module optical_tx_conditioner #(
  parameter int unsigned PERIOD_CLKS = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] src_sel,
  input  logic       mod_en,
  input  logic [1:0] duty_code,
  input  logic       tx_invert,
  input  logic       rx_disable,
  input  logic       uart_tx,
  input  logic       wpulse,
  input  logic       varpulse,
  input  logic       gpo_bit,
  input  logic       pad_rx,
  output logic       pad_tx,
  output logic       uart_rx
);
  // named internal events for the checker
  logic sel_data;
  logic carrier;
  logic carrier_wrap;
  logic shaped;

  optx_src_mux u_mux (
    .sel(src_sel), .uart_tx(uart_tx), .wpulse(wpulse),
    .varpulse(varpulse), .gpo_bit(gpo_bit), .data(sel_data)
  );

  optx_carrier_gen #(.PERIOD_CLKS(PERIOD_CLKS)) u_car (
    .clk(clk), .rst_n(rst_n), .duty_code(duty_code),
    .carrier(carrier), .wrap(carrier_wrap)
  );

  optx_rx_gate u_rx (
    .rx_disable(rx_disable), .pad_rx(pad_rx), .uart_rx(uart_rx)
  );

  // space (0) keys the carrier, mark (1) stays dark
  assign shaped = mod_en ? (~sel_data & carrier) : sel_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pad_tx <= 1'b0;
    else        pad_tx <= shaped ^ tx_invert;
  end
endmodule

// File: rtl/optx_checker.sv
module optx_checker (
  input logic clk,
  input logic rst_n,
  input logic mod_en,
  input logic tx_invert,
  input logic rx_disable,
  input logic pad_tx,
  input logic uart_rx,
  input logic sel_data,
  input logic carrier,
  input logic carrier_wrap
);
  // R2
  direct_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(!mod_en)) |-> (pad_tx == ($past(sel_data) ^ $past(tx_invert))));

  // R4
  mark_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(mod_en) && $past(sel_data)) |-> (pad_tx == $past(tx_invert)));

  // R5
  phase_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(carrier_wrap) |-> carrier);

  // R6
  wrap_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    carrier_wrap |-> !carrier);

  // R7
  rx_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_disable |-> uart_rx);
endmodule

bind optical_tx_conditioner optx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .tx_invert(tx_invert),
  .rx_disable(rx_disable), .pad_tx(pad_tx), .uart_rx(uart_rx),
  .sel_data(sel_data), .carrier(carrier), .carrier_wrap(carrier_wrap)
);

// File: tb/optical_tx_conditioner_tb.sv
module optical_tx_conditioner_tb;
  localparam int CLK_PERIOD = 10;
  localparam int P = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] src_sel = 2'd0, duty_code = 2'd0;
  logic mod_en = 0, tx_invert = 0, rx_disable = 0;
  logic uart_tx = 1, wpulse = 0, varpulse = 0, gpo_bit = 0, pad_rx = 1;
  logic pad_tx, uart_rx;

  int n_run = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  optical_tx_conditioner #(.PERIOD_CLKS(P)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .mod_en(mod_en),
    .duty_code(duty_code), .tx_invert(tx_invert), .rx_disable(rx_disable),
    .uart_tx(uart_tx), .wpulse(wpulse), .varpulse(varpulse),
    .gpo_bit(gpo_bit), .pad_rx(pad_rx), .pad_tx(pad_tx), .uart_rx(uart_rx)
  );

  // {sel[1:0], inv, uart_tx, wpulse, varpulse, gpo, expected}
  localparam logic [7:0] VEC [8] = '{
    {2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
    {2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    {2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
    {2'd1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
    {2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    {2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
    {2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
    {2'd3, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}
  };

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      finish_run();
    end
  end

  // count high samples over one full period, starting after settle cycles
  task automatic count_high(output int highs);
    highs = 0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < P; i++) begin
      @(negedge clk);
      if (pad_tx) highs++;
    end
  endtask

  initial begin
    int h, t0, t1;
    logic prev;
    // R8 reset state
    repeat (3) @(negedge clk);
    check("R8 pad_tx in reset", pad_tx, 0);
    rst_n = 1;

    // R1 R2 R3 vector table, unmodulated
    foreach (VEC[k]) begin
      @(negedge clk);
      {src_sel, tx_invert, uart_tx, wpulse, varpulse, gpo_bit} = VEC[k][7:1];
      @(negedge clk);
      check($sformatf("R1/R2/R3 vec %0d", k), pad_tx, VEC[k][0]);
    end

    // R7 receive gate
    rx_disable = 1; pad_rx = 0; #1;
    check("R7 disabled forces idle", uart_rx, 1);
    rx_disable = 0; #1;
    check("R7 enabled passes 0", uart_rx, 0);
    pad_rx = 1; #1;
    check("R7 enabled passes 1", uart_rx, 1);

    // R6 duty codes, space state, no invert
    @(negedge clk);
    src_sel = 2'd0; tx_invert = 0; uart_tx = 0; mod_en = 1;
    for (int d = 0; d < 4; d++) begin
      duty_code = 2'(d);
      count_high(h);
      check($sformatf("R6 duty code %0d", d), h, P / 2 - d * (P / 8));
    end

    // R3 R6 inverted duty
    tx_invert = 1; duty_code = 2'd2;
    count_high(h);
    check("R3/R6 inverted code 2", h, P - P / 4);
    tx_invert = 0;

    // R5 period between rising edges
    duty_code = 2'd1;
    repeat (2) @(negedge clk);
    prev = pad_tx; t0 = -1; t1 = -1;
    for (int i = 0; i < 3 * P && t1 < 0; i++) begin
      @(negedge clk);
      if (pad_tx && !prev) begin
        if (t0 < 0) t0 = i; else t1 = i;
      end
      prev = pad_tx;
    end
    check("R5 carrier period", t1 - t0, P);

    // R4 mark state idle, plain and inverted, via GPO source
    src_sel = 2'd3; gpo_bit = 1;
    count_high(h);
    check("R4 mark idle", h, 0);
    tx_invert = 1;
    count_high(h);
    check("R4/R3 mark idle inverted", h, P);
    tx_invert = 0;

    // R8 phase restart: reset then first sample is high for P/8 cycles
    duty_code = 2'd3; src_sel = 2'd0; uart_tx = 0;
    rst_n = 0;
    @(negedge clk);
    check("R8 pad_tx cleared by reset", pad_tx, 0);
    rst_n = 1;
    h = 0;
    for (int i = 0; i < P / 8 + 1; i++) begin
      @(negedge clk);
      if (pad_tx) h++;
    end
    check("R8 first burst after reset", h, P / 8);

    finish_run();
  end
endmodule